// File: doc/BRIEF.md
# Width-Adaptive Byte FIFO Pair

This block sits between a register bus and a card data engine and holds the data bytes of one transfer in two circular byte queues of 32 entries: one toward the card (transmit) and one from the card (receive). A bus access is 1, 2 or 4 bytes wide. A write to the transmit queue splits the bus word into bytes. A read from the receive queue packs bytes into a bus word. In both cases the byte in the most significant lane of the access comes first.

On the card side the transmit queue offers one byte per cycle through a valid/ready pop port. The receive queue accepts one byte per cycle through a valid/ready push port. A transfer is started with a direction, a block count and a block length. The product of count and length is loaded into a remaining-byte counter, and every byte that crosses the card side decrements it. When the counter reaches zero the block pulses a data-done event, and a card-bound transfer also pulses a program-done event. Two request flags, one per queue, tell the interrupt logic when the bus should service a queue.

The controller has four states. `XS_IDLE` is the resting state. `XS_FETCH` moves bytes from the card into the receive queue. `XS_DRAIN` moves bytes from the transmit queue to the card. `XS_DONE` lasts one cycle and emits the completion events. The transitions are:
- start with a non-zero product: `XS_IDLE`/any to `XS_FETCH` or `XS_DRAIN`, chosen by direction.
- start with a zero product: any state to `XS_DONE`.
- the last byte moves: `XS_FETCH` or `XS_DRAIN` to `XS_DONE`.
- after its single cycle: `XS_DONE` to `XS_IDLE`.

Top module: `byte_fifo_pair`

## Requirements
- R1: After reset both queues are empty, the state is idle, `rx_req`, `tx_req`, `tx_valid`, `rx_ready`, `xfer_active`, `data_done` and `prog_done` are 0, and `bus_rdata` is 0.
- R2: A read (`bus_rd_en`) pops min(N, level) receive bytes. The first byte popped goes to byte lane N-1 (bits 8N-1..8N-8), the next to lane N-2, and so on. Lanes with no byte and lanes at N and above read 0. `bus_rdata` shows the word from the cycle after the read.
- R3: A write (`bus_wr_en`) pushes min(N, free space) bytes, taking lane N-1 of `bus_wdata` first, then lane N-2, and so on. Bytes beyond a full queue (32 held) are dropped.
- R4: A bus read clears `rx_req` and a bus write clears `tx_req`. When a card byte enters the receive queue in the same cycle as a bus read, `rx_req` ends up set.
- R5: In a card-bound transfer the block offers one byte per cycle while the remaining count and the queue are both non-zero. When the queue is empty and bytes remain, `tx_req` is set from the next cycle on.
- R6: In a card-to-bus transfer the block accepts one byte per cycle while the remaining count is non-zero and the queue holds fewer than 32 bytes. Every accepted byte sets `rx_req`.
- R7: On start the remaining count becomes `xfer_blk_cnt * xfer_blk_len`. The cycle after the last byte moves, `data_done` pulses for one cycle and `xfer_active` drops. `prog_done` pulses with it only when `xfer_to_card`=1. A zero product gives the pulses without any byte moving.
- R8: `txflush_wr` with `txflush_bit`=1 discards all bytes in the transmit queue. With `txflush_bit`=0 it has no effect.
- R9: `xfer_start` empties both queues.
- R10: The `bus_width` encoding is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes.
- R11: While no transfer is active, `tx_valid` and `rx_ready` stay 0, even when the transmit queue holds bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd_en | input | 1 | Bus read of the receive queue |
| bus_wr_en | input | 1 | Bus write of the transmit queue |
| bus_width | input | 2 | Access width code (R10) |
| bus_wdata | input | 8*LANES | Write word |
| bus_rdata | output | 8*LANES | Packed read word, registered |
| txflush_wr | input | 1 | Write strobe of the discard control |
| txflush_bit | input | 1 | Discard request bit |
| xfer_start | input | 1 | Start a transfer (one-cycle strobe) |
| xfer_to_card | input | 1 | 1 = bus to card, 0 = card to bus |
| xfer_blk_cnt | input | BLKCNT_W | Number of blocks |
| xfer_blk_len | input | BLKLEN_W | Bytes per block |
| tx_byte | output | 8 | Byte offered to the card |
| tx_valid | output | 1 | `tx_byte` is valid |
| tx_ready | input | 1 | Card takes `tx_byte` |
| rx_byte | input | 8 | Byte from the card |
| rx_valid | input | 1 | `rx_byte` is valid |
| rx_ready | output | 1 | Block accepts `rx_byte` |
| rx_req | output | 1 | Receive service request flag |
| tx_req | output | 1 | Transmit service request flag |
| xfer_active | output | 1 | Fetch or drain in progress |
| data_done | output | 1 | One-cycle transfer completion pulse |
| prog_done | output | 1 | One-cycle completion pulse, card-bound only |

## Verification
A card byte can enter the receive queue in the same cycle that the bus pops it. That cycle both sets and clears `rx_req`, and it changes the queue level in both directions. The bench provokes this by holding `rx_valid` high in the exact cycle of a 1-byte bus read. It then judges two things: the read returns the older byte while `rx_req` stays set, and a second read returns the newly entered byte and clears the flag. The transmit side gets the matching treatment. A bus write arrives while the drain engine is starved, and `tx_req` must fall.

// File: rtl/xfp_pkg.sv
package xfp_pkg;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_FETCH = 2'd1,
        XS_DRAIN = 2'd2,
        XS_DONE  = 2'd3
    } xfer_state_t;

endpackage

// File: rtl/xfp_ring.sv
module xfp_ring #(
    parameter int DEPTH = 32,
    parameter int LANES = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int NW    = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic [NW-1:0]         push_n,
    input  logic [LANES-1:0][7:0] push_bytes,
    input  logic [NW-1:0]         pop_n,
    output logic [LANES-1:0][7:0] head_bytes,
    output logic [LVL_W-1:0]      level
);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [7:0]       mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            rd_ptr <= wr_ptr;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(push_n);
            rd_ptr <= rd_ptr + PTR_W'(pop_n);
            level  <= level + LVL_W'(push_n) - LVL_W'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (!flush && i < int'(push_n)) begin
                mem[wr_ptr + PTR_W'(i)] <= push_bytes[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            head_bytes[i] = mem[rd_ptr + PTR_W'(i)];
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (LVL_W'(pop_n) <= level)); // R2
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0)); // R8

endmodule

// File: rtl/xfp_lane_pack.sv
module xfp_lane_pack #(
    parameter int DEPTH = 32,
    parameter int LANES = 4,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int NW    = $clog2(LANES + 1),
    localparam int BW    = 8 * LANES
) (
    input  logic                  bus_rd_en,
    input  logic                  bus_wr_en,
    input  logic [1:0]            bus_width,
    input  logic [BW-1:0]         bus_wdata,
    input  logic [LVL_W-1:0]      tx_level,
    input  logic [LVL_W-1:0]      rx_level,
    input  logic [LANES-1:0][7:0] rx_head,
    output logic [NW-1:0]         tx_push_n,
    output logic [LANES-1:0][7:0] tx_push_bytes,
    output logic [NW-1:0]         rx_pop_n,
    output logic [BW-1:0]         rd_word
);

    int nbytes;
    int tx_free;
    int tx_k;
    int rx_k;

    // access width in bytes, capped at the bus width (R10)
    always_comb begin
        nbytes = 1 << bus_width;
        if (nbytes > LANES) nbytes = LANES;
    end

    // unpack toward the transmit queue, top lane first (R3)
    always_comb begin
        tx_free = DEPTH - int'(tx_level);
        tx_k    = 0;
        if (bus_wr_en) tx_k = (nbytes < tx_free) ? nbytes : tx_free;
        tx_push_n = NW'(tx_k);
        for (int j = 0; j < LANES; j++) begin
            tx_push_bytes[j] = 8'h00;
            if (j < nbytes) tx_push_bytes[j] = bus_wdata[8*(nbytes-1-j) +: 8];
        end
    end

    // pack from the receive queue, first byte into the top lane (R2)
    always_comb begin
        rx_k = 0;
        if (bus_rd_en) rx_k = (nbytes < int'(rx_level)) ? nbytes : int'(rx_level);
        rx_pop_n = NW'(rx_k);
        rd_word  = '0;
        for (int j = 0; j < LANES; j++) begin
            if (j < rx_k) rd_word[8*(nbytes-1-j) +: 8] = rx_head[j];
        end
    end

endmodule

// File: rtl/xfp_xfer_ctl.sv
module xfp_xfer_ctl
    import xfp_pkg::*;
#(
    parameter int BLKCNT_W = 16,
    parameter int BLKLEN_W = 12,
    localparam int CNT_W   = BLKCNT_W + BLKLEN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                to_card,
    input  logic [BLKCNT_W-1:0] blk_cnt,
    input  logic [BLKLEN_W-1:0] blk_len,
    input  logic                tx_empty,
    input  logic                rx_full,
    input  logic                tx_ready,
    input  logic                rx_valid,
    output logic                tx_valid,
    output logic                rx_ready,
    output logic                tx_pop,
    output logic                rx_push,
    output logic                active,
    output logic                starved,
    output logic                data_done,
    output logic                prog_done
);

    xfer_state_t      state;
    xfer_state_t      nstate;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] total;
    logic             dir_q;

    assign total = CNT_W'(blk_cnt) * CNT_W'(blk_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= XS_IDLE;
            remain <= '0;
            dir_q  <= 1'b0;
        end else begin
            state <= nstate;
            if (start) begin
                remain <= total;
                dir_q  <= to_card;
            end else if (tx_pop || rx_push) begin
                remain <= remain - 1'b1;
            end
        end
    end

    always_comb begin
        nstate = state;
        unique case (state)
            XS_IDLE:  nstate = XS_IDLE;
            XS_FETCH: if (rx_push && remain == CNT_W'(1)) nstate = XS_DONE;
            XS_DRAIN: if (tx_pop && remain == CNT_W'(1)) nstate = XS_DONE;
            XS_DONE:  nstate = XS_IDLE;
        endcase
        if (start) begin
            if (total == '0)  nstate = XS_DONE;
            else if (to_card) nstate = XS_DRAIN;
            else              nstate = XS_FETCH;
        end
    end

    always_comb begin
        tx_valid  = 1'b0;
        rx_ready  = 1'b0;
        active    = 1'b0;
        starved   = 1'b0;
        data_done = 1'b0;
        prog_done = 1'b0;
        unique case (state)
            XS_IDLE: ;
            XS_FETCH: begin
                active   = 1'b1;
                rx_ready = !rx_full;
            end
            XS_DRAIN: begin
                active   = 1'b1;
                tx_valid = !tx_empty;
                starved  = tx_empty;
            end
            XS_DONE: begin
                data_done = 1'b1;
                prog_done = dir_q;
            end
        endcase
        tx_pop  = tx_valid && tx_ready;
        rx_push = rx_ready && rx_valid;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        data_done && !start |=> !data_done); // R7
    AST_PROG_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |-> data_done); // R7
    AST_LIVE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (remain != '0)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!tx_valid && !rx_ready)); // R11
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop || rx_push) && !start |=> remain == $past(remain) - 1'b1); // R5

endmodule

// File: rtl/byte_fifo_pair.sv
module byte_fifo_pair #(
    parameter int DEPTH    = 32,
    parameter int LANES    = 4,
    parameter int BLKCNT_W = 16,
    parameter int BLKLEN_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_rd_en,
    input  logic                  bus_wr_en,
    input  logic [1:0]            bus_width,
    input  logic [8*LANES-1:0]    bus_wdata,
    output logic [8*LANES-1:0]    bus_rdata,
    input  logic                  txflush_wr,
    input  logic                  txflush_bit,
    input  logic                  xfer_start,
    input  logic                  xfer_to_card,
    input  logic [BLKCNT_W-1:0]   xfer_blk_cnt,
    input  logic [BLKLEN_W-1:0]   xfer_blk_len,
    output logic [7:0]            tx_byte,
    output logic                  tx_valid,
    input  logic                  tx_ready,
    input  logic [7:0]            rx_byte,
    input  logic                  rx_valid,
    output logic                  rx_ready,
    output logic                  rx_req,
    output logic                  tx_req,
    output logic                  xfer_active,
    output logic                  data_done,
    output logic                  prog_done
);

    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int NW    = $clog2(LANES + 1);
    localparam int BW    = 8 * LANES;

    logic [LVL_W-1:0]      tx_level, rx_level;
    logic [LANES-1:0][7:0] tx_head, rx_head;
    logic [LANES-1:0][7:0] tx_push_bytes, rx_push_bytes;
    logic [NW-1:0]         tx_push_n, rx_pop_n, tx_pop_n, rx_push_n;
    logic [BW-1:0]         rd_word;
    logic                  tx_pop, rx_push, starved;
    logic                  tx_flush, rx_flush;

    assign tx_flush = xfer_start || (txflush_wr && txflush_bit);
    assign rx_flush = xfer_start;
    assign tx_pop_n  = NW'(tx_pop);
    assign rx_push_n = NW'(rx_push);
    assign tx_byte   = tx_head[0];

    always_comb begin
        rx_push_bytes    = '0;
        rx_push_bytes[0] = rx_byte;
    end

    xfp_lane_pack #(.DEPTH(DEPTH), .LANES(LANES)) u_pack (
        .bus_rd_en     (bus_rd_en),
        .bus_wr_en     (bus_wr_en),
        .bus_width     (bus_width),
        .bus_wdata     (bus_wdata),
        .tx_level      (tx_level),
        .rx_level      (rx_level),
        .rx_head       (rx_head),
        .tx_push_n     (tx_push_n),
        .tx_push_bytes (tx_push_bytes),
        .rx_pop_n      (rx_pop_n),
        .rd_word       (rd_word)
    );

    xfp_ring #(.DEPTH(DEPTH), .LANES(LANES)) u_txq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (tx_flush),
        .push_n     (tx_push_n),
        .push_bytes (tx_push_bytes),
        .pop_n      (tx_pop_n),
        .head_bytes (tx_head),
        .level      (tx_level)
    );

    xfp_ring #(.DEPTH(DEPTH), .LANES(LANES)) u_rxq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (rx_flush),
        .push_n     (rx_push_n),
        .push_bytes (rx_push_bytes),
        .pop_n      (rx_pop_n),
        .head_bytes (rx_head),
        .level      (rx_level)
    );

    xfp_xfer_ctl #(.BLKCNT_W(BLKCNT_W), .BLKLEN_W(BLKLEN_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (xfer_start),
        .to_card   (xfer_to_card),
        .blk_cnt   (xfer_blk_cnt),
        .blk_len   (xfer_blk_len),
        .tx_empty  (tx_level == '0),
        .rx_full   (rx_level == LVL_W'(DEPTH)),
        .tx_ready  (tx_ready),
        .rx_valid  (rx_valid),
        .tx_valid  (tx_valid),
        .rx_ready  (rx_ready),
        .tx_pop    (tx_pop),
        .rx_push   (rx_push),
        .active    (xfer_active),
        .starved   (starved),
        .data_done (data_done),
        .prog_done (prog_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            rx_req    <= 1'b0;
            tx_req    <= 1'b0;
        end else begin
            if (bus_rd_en) bus_rdata <= rd_word;
            if (rx_push)        rx_req <= 1'b1;
            else if (bus_rd_en) rx_req <= 1'b0;
            if (bus_wr_en)    tx_req <= 1'b0;
            else if (starved) tx_req <= 1'b1;
        end
    end

    AST_RXREQ_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> rx_req); // R6
    AST_TXREQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_en |=> !tx_req); // R4
    AST_DRY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_en && rx_level == '0 |=> bus_rdata == '0); // R2

endmodule

// File: tb/byte_fifo_pair_tb.sv
module byte_fifo_pair_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd_en = 1'b0, bus_wr_en = 1'b0;
    logic [1:0]  bus_width = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        txflush_wr = 1'b0, txflush_bit = 1'b0;
    logic        xfer_start = 1'b0, xfer_to_card = 1'b0;
    logic [15:0] xfer_blk_cnt = '0;
    logic [11:0] xfer_blk_len = '0;
    logic [7:0]  tx_byte;
    logic        tx_valid, tx_ready = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready, rx_req, tx_req, xfer_active, data_done, prog_done;

    int checks = 0, fails = 0;
    int nlog = 0, n_dd = 0, n_pd = 0;
    logic [7:0] blog [64];

    always #5 clk = ~clk;

    byte_fifo_pair u_dut (.*);

    always @(negedge clk) begin
        if (tx_valid && tx_ready && nlog < 64) begin
            blog[nlog] = tx_byte;
            nlog++;
        end
        if (data_done) n_dd++;
        if (prog_done) n_pd++;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic bus_write(logic [1:0] w, logic [31:0] d);
        bus_wr_en = 1'b1; bus_width = w; bus_wdata = d;
        step();
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] w, output logic [31:0] d);
        bus_rd_en = 1'b1; bus_width = w;
        step();
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic start(logic to_card, logic [15:0] c, logic [11:0] l);
        xfer_start = 1'b1; xfer_to_card = to_card; xfer_blk_cnt = c; xfer_blk_len = l;
        step();
        xfer_start = 1'b0;
    endtask

    task automatic drain(int n);
        tx_ready = 1'b1;
        repeat (n) step();
        tx_ready = 1'b0;
    endtask

    task automatic flush(logic b);
        txflush_wr = 1'b1; txflush_bit = b;
        step();
        txflush_wr = 1'b0;
    endtask

    task automatic card_push(logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        do @(negedge clk); while (!rx_ready);
        step();
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 rx_ready", rx_ready, 0);
        chk("R1 flags", {rx_req, tx_req, xfer_active, data_done, prog_done}, 0);
        chk("R1 rdata", bus_rdata, 0);
    endtask

    task automatic t_idle_and_start_flush();
        int base;
        bus_write(2'd2, 32'hDEADBEEF);
        tx_ready = 1'b1;
        repeat (3) step();
        chk("R11 idle tx_valid", tx_valid, 0);
        chk("R11 idle rx_ready", rx_ready, 0);
        base = nlog;
        start(1'b1, 16'd1, 12'd4);
        repeat (2) step();
        chk("R9 no stale byte sent", nlog - base, 0);
        chk("R9 starved tx_req", tx_req, 1);
        bus_write(2'd2, 32'h01020304);
        repeat (6) step();
        tx_ready = 1'b0;
        chk("R3 word order", {blog[base], blog[base+1], blog[base+2], blog[base+3]}, 32'h01020304);
    endtask

    task automatic t_tx_pack();
        int base = nlog;
        int dd = n_dd;
        int pd = n_pd;
        start(1'b1, 16'd1, 12'd7);
        step();
        chk("R5 tx_req set while starved", tx_req, 1);
        bus_write(2'd2, 32'hA1B2C3D4);
        chk("R4 write clears tx_req", tx_req, 0);
        bus_write(2'd1, 32'h9999E5F6);
        bus_write(2'd0, 32'h88888877);
        drain(10);
        chk("R5 byte count", nlog - base, 7);
        chk("R3 4-byte lanes", {blog[base], blog[base+1], blog[base+2], blog[base+3]}, 32'hA1B2C3D4);
        chk("R10 2- and 1-byte lanes", {8'h0, blog[base+4], blog[base+5], blog[base+6]}, 32'h00E5F677);
        chk("R7 write data_done", n_dd - dd, 1);
        chk("R7 write prog_done", n_pd - pd, 1);
        chk("R7 inactive", xfer_active, 0);
    endtask

    task automatic t_tx_overflow_flush();
        int base = nlog;
        start(1'b1, 16'd1, 12'd64);
        for (int k = 0; k < 9; k++)
            bus_write(2'd2, {8'(4*k), 8'(4*k+1), 8'(4*k+2), 8'(4*k+3)});
        drain(40);
        chk("R3 capped at 32", nlog - base, 32);
        chk("R3 last kept byte", blog[base+31], 8'd31);
        chk("R5 re-request with bytes left", tx_req, 1);
        bus_write(2'd2, 32'h11223344);
        flush(1'b0);
        drain(1);
        chk("R8 bit clear keeps bytes", blog[base+32], 8'h11);
        flush(1'b1);
        bus_write(2'd0, 32'h0000005A);
        drain(1);
        chk("R8 discard", blog[base+33], 8'h5A);
    endtask

    task automatic t_rx_pack();
        logic [31:0] d;
        int dd = n_dd;
        int pd = n_pd;
        start(1'b0, 16'd2, 12'd3);
        for (int i = 0; i < 6; i++) card_push(8'(8'h10 + i));
        step();
        chk("R6 rx_req after fetch", rx_req, 1);
        chk("R7 read data_done", n_dd - dd, 1);
        chk("R7 no prog_done on read", n_pd - pd, 0);
        bus_read(2'd2, d);
        chk("R2 4-byte pack", d, 32'h10111213);
        chk("R4 read clears rx_req", rx_req, 0);
        bus_read(2'd2, d);
        chk("R2 zero fill", d, 32'h14150000);
        start(1'b0, 16'd1, 12'd3);
        card_push(8'hAA); card_push(8'hBB); card_push(8'hCC);
        bus_read(2'd1, d);
        chk("R10 2-byte read", d, 32'h0000AABB);
        bus_read(2'd0, d);
        chk("R10 1-byte read", d, 32'h000000CC);
        bus_read(2'd0, d);
        chk("R2 dry read", d, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        start(1'b0, 16'd1, 12'd4);
        card_push(8'h31);
        rx_valid = 1'b1; rx_byte = 8'h32;
        bus_rd_en = 1'b1; bus_width = 2'd0;
        step();
        rx_valid = 1'b0; bus_rd_en = 1'b0;
        chk("R4 same-cycle data", bus_rdata, 32'h31);
        chk("R4 push wins over clear", rx_req, 1);
        bus_read(2'd0, d);
        chk("R6 new byte kept", d, 32'h32);
        chk("R4 cleared after", rx_req, 0);
    endtask

    task automatic t_rx_full();
        logic [31:0] d;
        start(1'b0, 16'd5, 12'd8);
        for (int i = 0; i < 32; i++) card_push(8'(8'h40 + i));
        @(negedge clk);
        chk("R6 full stops fetch", rx_ready, 0);
        chk("R6 still active", xfer_active, 1);
        step();
        bus_read(2'd0, d);
        chk("R2 oldest first", d, 32'h40);
        @(negedge clk);
        chk("R6 space resumes fetch", rx_ready, 1);
        step();
        bus_read(2'd3, d);
        chk("R10 code 3 is 4 bytes", d, 32'h41424344);
    endtask

    task automatic t_zero_count();
        int dd = n_dd;
        int pd = n_pd;
        start(1'b1, 16'd3, 12'd0);
        repeat (2) step();
        chk("R7 zero count data_done", n_dd - dd, 1);
        chk("R7 zero count prog_done", n_pd - pd, 1);
        chk("R7 zero count inactive", xfer_active, 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_idle_and_start_flush();
        t_tx_pack();
        t_tx_overflow_flush();
        t_rx_pack();
        t_same_cycle();
        t_rx_full();
        t_zero_count();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule